// File: doc/BRIEF.md
# Shared Constant Multiplier Pair for a Hartley Transform Stage

This block scales eight signed fixed-point lanes by two fixed coefficients, using only two multipliers. Lanes are split into two groups of four. Every lane in group A is scaled by one constant and every lane in group B by the other. Each group has a single multiplier, and that multiplier is time-shared across its four lanes.

A new sample set is accepted with a valid/ready handshake and copied into holding registers. A 2-bit slot counter then steps through the four lanes, one lane per clock. An input multiplexer picks the held operand for the current slot, and the product is steered back to that lane's output register. Because each coefficient is a build-time constant, each multiplier reduces to a sum of shifted copies of the operand. Products are rounded back to the input width and saturated.

The block sits between butterfly stages of a parallel fast Hartley transform datapath. It replaces eight dedicated multipliers with two, at the cost of four cycles per sample set.

Top module: `hartley_const_mul_pair`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and all eight output lanes read 0.
- R2: Group A lane k (bits [16k+15:16k] of grp_a_in and grp_a_out) produces round(x·COEF_A / 2^14), where COEF_A is a signed Q1.14 parameter (default 11585).
- R3: Group B lane k (bits [16k+15:16k] of grp_b_in and grp_b_out) produces round(x·COEF_B / 2^14), where COEF_B is a signed Q1.14 parameter (default −21407).
- R4: Rounding adds 2^13 to the full product and then shifts right arithmetically by 14. Exact halves therefore go toward +infinity: 8192·11585 gives 5793, and −8192·11585 gives −5792.
- R5: A rounded result above 32767 yields 32767, and one below −32768 yields −32768.
- R6: out_valid is a single-cycle pulse. It is high in the fourth cycle after the clock edge that accepts a set, meaning after the fourth rising edge that follows acceptance.
- R7: in_ready is 0 from the accepting edge until out_valid rises. Any in_valid asserted while in_ready is 0 is ignored, so it neither starts a sequence nor changes the outputs.
- R8: Lane inputs are sampled at the accepting edge, so changing them during the sequence has no effect on the results.
- R9: Output lanes keep their values between sequences, until a new sequence writes them.
- R10: Lane k of both groups is written at the (k+1)-th rising edge after acceptance. One edge after acceptance, lane 0 shows its new result while lane 1 still holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the slots and the samples |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample set offered |
| in_ready | output | 1 | Block idle, so a set can be taken |
| grp_a_in | input | 64 | Four signed lanes scaled by COEF_A |
| grp_b_in | input | 64 | Four signed lanes scaled by COEF_B |
| out_valid | output | 1 | All eight lanes updated (one-cycle pulse) |
| grp_a_out | output | 64 | Four scaled lanes of group A |
| grp_b_out | output | 64 | Four scaled lanes of group B |

## Verification
The assertions take for granted that a set is handed over only through the handshake, so the slot count starts only on an accepting edge. They also assume that no other source writes the output lanes. Within those assumptions, they check the pulse timing, the refusal while busy, and the stability of the outputs while idle.

The stimulus drives inputs only on falling edges. It sometimes holds in_valid high and changes the lane data while a sequence is running, to show that such traffic has no effect. Otherwise it offers a new set only after the previous pulse.

// File: rtl/hartley_const_mul_pair.sv
module hartley_const_mul_pair #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FRAC = 14,
  parameter int LANES = 4,
  parameter logic signed [CW-1:0] COEF_A = 16'sd11585,
  parameter logic signed [CW-1:0] COEF_B = -16'sd21407
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*DW-1:0] grp_a_in,
  input  logic [LANES*DW-1:0] grp_b_in,
  output logic                out_valid,
  output logic [LANES*DW-1:0] grp_a_out,
  output logic [LANES*DW-1:0] grp_b_out
);
  localparam int PW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int PRODW = DW + CW;
  localparam logic signed [PRODW:0] MAXV = {{(PRODW-DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PRODW:0] MINV = {{(PRODW-DW+2){1'b1}}, {(DW-1){1'b0}}};
  localparam logic signed [PRODW:0] HALF = (PRODW+1)'(1) <<< (FRAC-1);

  logic signed [DW-1:0] hold_a [LANES];
  logic signed [DW-1:0] hold_b [LANES];
  logic signed [DW-1:0] lane_a [LANES];
  logic signed [DW-1:0] lane_b [LANES];
  logic [PW-1:0] slot;
  logic busy;
  logic accept, last_slot;
  logic signed [DW-1:0] res_a, res_b;

  function automatic logic signed [PRODW-1:0] const_mul(
    input logic signed [DW-1:0] x, input logic signed [CW-1:0] c);
    logic signed [PRODW-1:0] acc, xe;
    acc = '0;
    xe = PRODW'(x);
    for (int k = 0; k < CW; k++) begin
      if (c[k]) begin
        if (k == CW-1) acc = acc - (xe <<< k);
        else           acc = acc + (xe <<< k);
      end
    end
    return acc;
  endfunction

  function automatic logic signed [DW-1:0] round_sat(input logic signed [PRODW-1:0] p);
    logic signed [PRODW:0] r;
    r = ((PRODW+1)'(p) + HALF) >>> FRAC;
    if (r > MAXV)      return MAXV[DW-1:0];
    else if (r < MINV) return MINV[DW-1:0];
    else               return r[DW-1:0];
  endfunction

  assign in_ready  = !busy;
  assign accept    = in_valid && !busy;
  assign last_slot = (slot == PW'(LANES-1));
  assign res_a = round_sat(const_mul(hold_a[slot], COEF_A));
  assign res_b = round_sat(const_mul(hold_b[slot], COEF_B));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= busy && last_slot;
      if (accept) begin
        busy <= 1'b1;
        slot <= '0;
      end else if (busy) begin
        slot <= slot + 1'b1;
        if (last_slot) busy <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_a[k] <= '0;
        hold_b[k] <= '0;
        lane_a[k] <= '0;
        lane_b[k] <= '0;
      end else begin
        if (accept) begin
          hold_a[k] <= grp_a_in[k*DW +: DW];
          hold_b[k] <= grp_b_in[k*DW +: DW];
        end
        if (busy && slot == PW'(k)) begin
          lane_a[k] <= res_a;
          lane_b[k] <= res_b;
        end
      end
    end
    assign grp_a_out[k*DW +: DW] = lane_a[k];
    assign grp_b_out[k*DW +: DW] = lane_b[k];
  end
endmodule

// File: rtl/hartley_const_mul_pair_chk.sv
module hartley_const_mul_pair_chk #(
  parameter int DW = 16,
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic [LANES*DW-1:0] grp_a_out,
  input logic [LANES*DW-1:0] grp_b_out
);
  localparam int CNW = $clog2(LANES+1);
  logic [CNW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (in_valid && in_ready) cnt_q <= CNW'(1);
    else if (cnt_q != '0 && cnt_q < CNW'(LANES)) cnt_q <= cnt_q + 1'b1;
    else cnt_q <= '0;
  end

  // R6
  pulse_after_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNW'(LANES) |=> out_valid);
  // R6
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(cnt_q == CNW'(LANES)));
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R7
  refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R7
  ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_ready) && in_ready) |-> ($stable(grp_a_out) && $stable(grp_b_out)));
endmodule

bind hartley_const_mul_pair hartley_const_mul_pair_chk #(.DW(DW), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .grp_a_out(grp_a_out), .grp_b_out(grp_b_out));

// File: tb/hartley_const_mul_pair_tb.sv
module hartley_const_mul_pair_tb_top;
  localparam int DW = 16;
  localparam longint CA = 11585;
  localparam longint CB = -21407;
  localparam int NV = 6;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic in_ready, out_valid;
  logic [63:0] a_in = '0, b_in = '0;
  logic [63:0] a_out, b_out;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  hartley_const_mul_pair dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .grp_a_in(a_in), .grp_b_in(b_in), .out_valid(out_valid),
    .grp_a_out(a_out), .grp_b_out(b_out));

  // {group A lanes 3..0, group B lanes 3..0}
  localparam logic [127:0] STIM [NV] = '{
    {16'sd100, -16'sd100, 16'sd1, 16'sd0, 16'sd7, -16'sd7, 16'sd1000, -16'sd1000},
    {16'sd8192, -16'sd8192, 16'sd16384, -16'sd16384, 16'sd8192, -16'sd8192, 16'sd3, -16'sd3},
    {16'sd32767, -16'sd32768, 16'sd12345, -16'sd23456, 16'sd32767, -16'sd32768, 16'sd25000, -16'sd25000},
    {16'sd2, 16'sd3, 16'sd5, -16'sd1, 16'sd1, -16'sd1, 16'sd2, -16'sd2},
    {16'sd20000, -16'sd20000, 16'sd30000, -16'sd30000, 16'sd24000, -16'sd24000, 16'sd26000, -16'sd26000},
    {16'sd4321, -16'sd1234, 16'sd999, -16'sd31000, 16'sd11111, -16'sd22222, 16'sd333, -16'sd4444}
  };

  function automatic longint expect_mul(input longint x, input longint c);
    longint r;
    r = (x * c + 8192) >>> 14;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic longint lane(input logic [63:0] v, input int k);
    return longint'($signed(v[k*16 +: 16]));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_lanes(input string req, input logic [63:0] ai, input logic [63:0] bi);
    for (int k = 0; k < 4; k++) begin
      check(req, lane(a_out, k), expect_mul(lane(ai, k), CA));
      check(req, lane(b_out, k), expect_mul(lane(bi, k), CB));
    end
  endtask

  // Offer a set at a falling edge; return at the falling edge after acceptance.
  task automatic offer(input logic [63:0] ai, input logic [63:0] bi);
    @(negedge clk);
    a_in = ai; b_in = bi; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] pa, pb;
    repeat (3) @(negedge clk);
    // R1
    check("R1 valid", out_valid, 0);
    check("R1 ready", in_ready, 1);
    check("R1 lanes", a_out | b_out, 0);
    rst_n = 1;

    // R2 R3 R4 R5: table walk with R6 timing per set
    for (int v = 0; v < NV; v++) begin
      offer(STIM[v][127:64], STIM[v][63:0]);
      check("R7 ready low", in_ready, 0);
      repeat (3) @(negedge clk);
      check("R6 not yet", out_valid, 0);
      @(negedge clk);
      check("R6 pulse", out_valid, 1);
      check_lanes("R2/R3 lanes", STIM[v][127:64], STIM[v][63:0]);
      @(negedge clk);
      check("R6 single", out_valid, 0);
    end

    // R4 directed ties
    check("R4 tie pos", expect_mul(8192, CA), 5793);
    offer(STIM[1][127:64], STIM[1][63:0]);
    repeat (4) @(negedge clk);
    check("R4 A tie +", lane(a_out, 3), 5793);
    check("R4 A tie -", lane(a_out, 2), -5792);
    check("R4 B tie +", lane(b_out, 3), -10703);
    check("R4 B tie -", lane(b_out, 2), 10704);
    // R5 saturation on group B
    offer(STIM[2][127:64], STIM[2][63:0]);
    repeat (4) @(negedge clk);
    check("R5 sat low", lane(b_out, 3), -32768);
    check("R5 sat high", lane(b_out, 2), 32767);

    // R10 lane order and R8 capture, R7 ignore while busy
    pa = STIM[3][127:64]; pb = STIM[3][63:0];
    offer(pa, pb);
    in_valid = 1;
    a_in = STIM[0][127:64]; b_in = STIM[0][63:0];
    check("R10 lane0 pending", lane(a_out, 0), expect_mul(lane(STIM[2][127:64], 0), CA));
    @(negedge clk);
    check("R10 lane0 written", lane(a_out, 0), expect_mul(lane(pa, 0), CA));
    check("R10 lane1 old", lane(a_out, 1), expect_mul(lane(STIM[2][127:64], 1), CA));
    repeat (3) @(negedge clk);
    in_valid = 0;
    check("R6 pulse", out_valid, 1);
    check_lanes("R8 captured", pa, pb);

    // R9 hold and R7 no spurious start
    repeat (5) @(negedge clk);
    check("R9 no pulse", out_valid, 0);
    check_lanes("R9 held", pa, pb);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule